// File: doc/BRIEF.md
# Sliding-Window Parallel Sieve Matcher

This block is the fast first stage of a two-stage text scanner. It takes one 8-bit character per clock, keeps the four most recent characters in a shift register, and checks the resulting 32-bit key against a set of registered 4-character subpatterns. A nonzero index marks a partial match. A slower second stage then checks the full pattern. The block has no next-state logic. Its only scanning state is the character window, so the result depends only on the last four characters accepted.

The registered subpatterns are spread over a chain of lookup units. Each unit has a smaller main-memory address width than the one before it.

Each lookup unit works in three steps:
- It folds the key into a short address.
- It reads a candidate index from its main table at that address.
- It confirms the candidate by comparing the rest of the key against a tag held in its auxiliary table.

Each subpattern is loaded into exactly one unit. The per-unit results can therefore be merged with a plain OR into one match index. A configuration write port fills the tables, and the tables keep their contents through reset.

Top module: `sieve_matcher`

## Requirements
- R1: While reset is held and on the first clock after it, match_valid is 0 and match_idx is 0. The character window is cleared to all-zero with a fill count of 0.
- R2: A character is accepted only on a clock edge where char_vld is 1. When char_vld is 0 the window does not change, and the following output cycle reports match_valid = 0 with match_idx = 0. A held window never reports a match twice.
- R3: The key is the window with the newest character in bits 7:0 and the oldest of the four in bits 31:24.
- R4: match_valid can be 1 only once at least four characters have been accepted since the last reset. A key built partly from reset zeros never matches.
- R5: Unit j (j = 0..3) has address width P = 10 - j. Its address is key[P-1:0] XOR key[2P-1:P]. Its tag is key[31:P].
- R6: A unit returns its main-table word at the address when its auxiliary-table word at that address equals the tag, and returns 0 otherwise. The unit results are bitwise ORed into the match index.
- R7: The result for the window formed by a character accepted at clock edge n appears on the outputs after edge n+1, and not earlier.
- R8: match_valid is 1 exactly when the previous edge accepted a character, the window is full and the combined index is nonzero. match_idx equals the combined index when match_valid is 1 and is 0 otherwise.
- R9: With cfg_we = 1, cfg_unit picks the unit and cfg_mem picks the table (0 = main, 1 = aux).
  - cfg_addr bits above the unit's width are ignored.
  - The main table stores cfg_data[10:0]; the aux table stores cfg_data[31-P:0].
  - The new contents are used from the next edge on.
  - Table contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_vld | input | 1 | Accept char_in on this edge |
| char_in | input | 8 | Text character |
| cfg_we | input | 1 | Table write enable |
| cfg_unit | input | 2 | Lookup unit selected for the write |
| cfg_mem | input | 1 | Table select: 0 main, 1 aux |
| cfg_addr | input | 10 | Write address (low bits used per unit) |
| cfg_data | input | 25 | Write data (low bits used per table) |
| match_valid | output | 1 | Registered match flag |
| match_idx | output | 11 | Registered match index, 0 when no match |

## Verification
The bench builds the block with its default parameters:
- four units of widths 10, 9, 8 and 7 bits;
- an 11-bit index;
- an 8-bit character and a four-character window.

These tables are small enough to clear completely over the write port. A subpattern can then be placed in every unit, including the narrowest unit holding the largest index, 2047. The small widths also make it easy to build a decoy key: one that shares a stored key's fold address but differs in its tag. They also make it easy to exercise address aliasing above a unit's width and a key made up mostly of reset zeros.

// File: rtl/sieve_pkg.sv
// Shared definitions for the sliding-window parallel sieve matcher.
// Assumes the unit widths shrink by one bit per unit from the widest one.
package sieve_pkg;

    typedef enum logic {
        TBL_MAIN = 1'b0,
        TBL_AUX  = 1'b1
    } tbl_sel_e;

    // Main-table address width of unit j, given the widest unit's width.
    function automatic int unit_width(input int widest, input int j);
        return widest - j;
    endfunction

    // Larger of two integers, used for sizing shared buses.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sieve_window.sv
// Character window: holds the last WIN_CHARS accepted characters, newest in
// the low byte, and counts accepted characters up to WIN_CHARS.
// Assumes a synchronous active-low reset. Shifts only when char_vld is high.
module sieve_window #(
    parameter int CHAR_W    = 8,
    parameter int WIN_CHARS = 4,
    localparam int KEY_W    = CHAR_W * WIN_CHARS,
    localparam int FILL_W   = $clog2(WIN_CHARS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_vld,
    input  logic [CHAR_W-1:0] char_in,
    output logic [KEY_W-1:0]  key,
    output logic              full,
    output logic              fresh
);

    logic [KEY_W-1:0]  win_q;
    logic [FILL_W-1:0] fill_q;

    // Shift the newest character into the low byte when one is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (char_vld) begin
            win_q <= {win_q[KEY_W-CHAR_W-1:0], char_in};
        end
    end

    // Count accepted characters, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (char_vld && (fill_q != FILL_W'(WIN_CHARS))) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // Mark that the window was updated on the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh <= 1'b0;
        end else begin
            fresh <= char_vld;
        end
    end

    assign key  = win_q;
    assign full = (fill_q == FILL_W'(WIN_CHARS));

    // R2: an accepted character lands in the low byte
    p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(char_vld) && $past(rst_n) |-> win_q[CHAR_W-1:0] == $past(char_in));

    // R2: without a character the window holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(char_vld) && $past(rst_n) |-> $stable(win_q));

    // R4: the fill count never passes the window length
    p_fill_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(WIN_CHARS));

endmodule

// File: rtl/sieve_table.sv
// Write-port memory with an asynchronous read, used for the main and the
// auxiliary table of a lookup unit. Contents are not cleared by reset;
// software is assumed to load every entry before relying on it.
module sieve_table #(
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store a configuration word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R9: a write is visible at its address on the next cycle
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/sieve_unit.sv
// One index generation unit. It folds the key into a P-bit address, reads a
// candidate index from the main table and keeps it only when the aux table
// holds the key's upper KEY_W-P bits at that address. Assumes 2*P <= KEY_W.
module sieve_unit #(
    parameter int KEY_W = 32,
    parameter int P     = 10,
    parameter int IDX_W = 11,
    localparam int TAG_W = KEY_W - P
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key,
    input  logic             we_main,
    input  logic             we_aux,
    input  logic [P-1:0]     cfg_addr,
    input  logic [IDX_W-1:0] main_wdata,
    input  logic [TAG_W-1:0] aux_wdata,
    output logic [IDX_W-1:0] hit
);

    logic [P-1:0]     fold_addr;
    logic [TAG_W-1:0] key_tag;
    logic [IDX_W-1:0] cand_idx;
    logic [TAG_W-1:0] stored_tag;
    logic             tag_eq;

    // Fold the low 2P key bits into the table address; the rest is the tag.
    always_comb begin
        fold_addr = key[P-1:0] ^ key[2*P-1:P];
        key_tag   = key[KEY_W-1:P];
    end

    sieve_table #(.AW(P), .DW(IDX_W)) main_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_main),
        .waddr (cfg_addr),
        .wdata (main_wdata),
        .raddr (fold_addr),
        .rdata (cand_idx)
    );

    sieve_table #(.AW(P), .DW(TAG_W)) aux_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_aux),
        .waddr (cfg_addr),
        .wdata (aux_wdata),
        .raddr (fold_addr),
        .rdata (stored_tag)
    );

    // Keep the candidate only when the stored tag confirms it.
    always_comb begin
        tag_eq = (stored_tag == key_tag);
        hit    = tag_eq ? cand_idx : '0;
    end

endmodule

// File: rtl/sieve_matcher.sv
// Top of the sliding-window parallel sieve matcher. One character per clock
// enters the window. The key goes to NUM_UNITS lookup units of shrinking
// width in parallel; their results are ORed and registered. Assumes each
// registered key is loaded into exactly one unit, so the OR is the index.
module sieve_matcher #(
    parameter int CHAR_W     = 8,
    parameter int WIN_CHARS  = 4,
    parameter int NUM_UNITS  = 4,
    parameter int ADDR_W_MAX = 10,
    parameter int IDX_W      = 11,
    localparam int KEY_W      = CHAR_W * WIN_CHARS,
    localparam int ADDR_W_MIN = ADDR_W_MAX - NUM_UNITS + 1,
    localparam int DATA_W     = sieve_pkg::max2(KEY_W - ADDR_W_MIN, IDX_W),
    localparam int SEL_W      = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_vld,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_unit,
    input  logic              cfg_mem,
    input  logic [ADDR_W_MAX-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              match_valid,
    output logic [IDX_W-1:0]  match_idx
);

    import sieve_pkg::*;

    logic [KEY_W-1:0] key;
    logic             win_full;
    logic             win_fresh;
    logic [IDX_W-1:0] unit_hit [NUM_UNITS];
    logic [IDX_W-1:0] comb_idx;
    logic             comb_valid;

    sieve_window #(.CHAR_W(CHAR_W), .WIN_CHARS(WIN_CHARS)) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_vld (char_vld),
        .char_in  (char_in),
        .key      (key),
        .full     (win_full),
        .fresh    (win_fresh)
    );

    for (genvar j = 0; j < NUM_UNITS; j++) begin : g_unit
        localparam int UP    = unit_width(ADDR_W_MAX, j);
        localparam int UTAG  = KEY_W - UP;
        localparam logic [SEL_W-1:0] UID = SEL_W'(j);
        logic sel;
        // Decode the write strobe for this unit.
        always_comb sel = cfg_we && (cfg_unit == UID);

        sieve_unit #(.KEY_W(KEY_W), .P(UP), .IDX_W(IDX_W)) unit_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .key        (key),
            .we_main    (sel && (tbl_sel_e'(cfg_mem) == TBL_MAIN)),
            .we_aux     (sel && (tbl_sel_e'(cfg_mem) == TBL_AUX)),
            .cfg_addr   (cfg_addr[UP-1:0]),
            .main_wdata (cfg_data[IDX_W-1:0]),
            .aux_wdata  (cfg_data[UTAG-1:0]),
            .hit        (unit_hit[j])
        );
    end

    // Merge the unit results with a plain OR.
    always_comb begin
        comb_idx = '0;
        for (int j = 0; j < NUM_UNITS; j++) begin
            comb_idx = comb_idx | unit_hit[j];
        end
        comb_valid = win_fresh && win_full && (comb_idx != '0);
    end

    // Register the qualified result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_valid <= 1'b0;
            match_idx   <= '0;
        end else begin
            match_valid <= comb_valid;
            match_idx   <= comb_valid ? comb_idx : '0;
        end
    end

    // R7: a reported match follows a character accepted two edges earlier
    p_valid_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> $past(char_vld, 2));

    // R8: no index is shown without the valid flag
    p_idx_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !match_valid |-> match_idx == '0);

    // R8: a valid match never carries index zero
    p_valid_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> match_idx != '0);

endmodule

// File: tb/sieve_matcher_tb_top.sv
// Bench: behavioural reference of the window and the unit tables, updated on
// every rising edge and compared with the outputs on every falling edge.
module sieve_matcher_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_vld = 1'b0;
    logic [7:0]  char_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_unit = '0;
    logic        cfg_mem = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [24:0] cfg_data = '0;
    logic        match_valid;
    logic [10:0] match_idx;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // reference state
    bit [31:0] m_win;
    int        m_fill;
    bit [10:0] ref_main [4][1024];
    bit [24:0] ref_aux  [4][1024];
    bit        exp_v_cur, exp_v_next;
    bit [10:0] exp_i_cur, exp_i_next;

    always #10 clk = ~clk;

    sieve_matcher dut_i (
        .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .char_in(char_in),
        .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_mem(cfg_mem),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .match_valid(match_valid), .match_idx(match_idx)
    );

    function automatic int uw(int u);
        return 10 - u;
    endfunction

    function automatic bit [31:0] fold(bit [31:0] k, int p);
        bit [31:0] m;
        m = (32'd1 << p) - 1;
        return (k & m) ^ ((k >> p) & m);
    endfunction

    function automatic bit [10:0] ref_lookup(bit [31:0] k);
        bit [10:0] acc;
        acc = '0;
        for (int u = 0; u < 4; u++) begin
            int a;
            a = int'(fold(k, uw(u)));
            if (32'(ref_aux[u][a]) == (k >> uw(u))) acc = acc | ref_main[u][a];
        end
        return acc;
    endfunction

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_win = '0; m_fill = 0;
            exp_v_cur = 0; exp_i_cur = '0; exp_v_next = 0; exp_i_next = '0;
        end else begin
            bit [10:0] li;
            exp_v_cur = exp_v_next; exp_i_cur = exp_i_next;
            if (cfg_we) begin
                int a;
                a = int'(cfg_addr) & ((1 << uw(int'(cfg_unit))) - 1);
                if (cfg_mem == 1'b0) ref_main[cfg_unit][a] = cfg_data[10:0];
                else ref_aux[cfg_unit][a] = cfg_data & ((25'd1 << (32 - uw(int'(cfg_unit)))) - 1);
            end
            if (char_vld) begin
                m_win = {m_win[23:0], char_in};
                if (m_fill < 4) m_fill++;
            end
            li = ref_lookup(m_win);
            exp_v_next = char_vld && (m_fill == 4) && (li != 0);
            exp_i_next = exp_v_next ? li : '0;
        end
    end

    // every-cycle comparison against the reference (R8)
    always @(negedge clk) begin
        if (!done && rst_n) begin
            checks++;
            if (match_valid !== exp_v_cur || match_idx !== exp_i_cur) begin
                fails++;
                $display("FAIL R8 cycle %0d: actual v=%0d idx=%0d expected v=%0d idx=%0d",
                         cycles, match_valid, match_idx, exp_v_cur, exp_i_cur);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual cycles=%0d expected < 200000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic idle();
        @(negedge clk);
        char_vld = 0; cfg_we = 0;
    endtask

    task automatic drive_char(input bit [7:0] c);
        @(negedge clk);
        char_vld = 1; char_in = c; cfg_we = 0;
    endtask

    task automatic cfg_write(input int u, input bit m, input int a, input bit [24:0] d);
        @(negedge clk);
        char_vld = 0; cfg_we = 1; cfg_unit = 2'(u); cfg_mem = m;
        cfg_addr = 10'(a); cfg_data = d;
    endtask

    task automatic load_vec(input int u, input bit [31:0] v, input bit [10:0] idx);
        int a;
        a = int'(fold(v, uw(u)));
        cfg_write(u, 1'b0, a, 25'(idx));
        cfg_write(u, 1'b1, a, 25'(v >> uw(u)));
    endtask

    task automatic feed4(input bit [31:0] k);
        for (int b = 3; b >= 0; b--) drive_char(k[b*8 +: 8]);
    endtask

    // compare outputs at the next falling edge with hand-derived values
    task automatic expect_out(input string tag, input bit v, input bit [10:0] i);
        @(negedge clk);
        checks++;
        if (match_valid !== v || match_idx !== i) begin
            fails++;
            $display("FAIL %s: actual v=%0d idx=%0d expected v=%0d idx=%0d",
                     tag, match_valid, match_idx, v, i);
        end
        char_vld = 0; cfg_we = 0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 0, 0);
        @(negedge clk); rst_n = 1;
        expect_out("R1 after reset", 0, 0);

        // clear all tables
        for (int u = 0; u < 4; u++)
            for (int a = 0; a < (1 << uw(u)); a++) begin
                cfg_write(u, 1'b0, a, '0);
                cfg_write(u, 1'b1, a, '0);
            end

        load_vec(0, 32'h41424344, 11'd5);
        load_vec(0, 32'h30313233, 11'd6);
        load_vec(1, 32'h11223344, 11'd100);
        load_vec(2, 32'hDEADBEEF, 11'd1023);
        load_vec(3, 32'h00000001, 11'd2047);
        // new table contents are already in place; reset again for R4
        @(negedge clk); rst_n = 0; char_vld = 0; cfg_we = 0;
        @(negedge clk); rst_n = 1;

        // R4: key 0x00000001 after a single character must not match
        drive_char(8'h01); idle();
        expect_out("R4 partial window", 0, 0);
        drive_char(8'h00); drive_char(8'h00); drive_char(8'h00); drive_char(8'h01);
        idle();
        expect_out("R6 unit3 max index", 1, 2047);

        // R3: byte order matters
        feed4(32'h44434241); idle();
        expect_out("R3 reversed order", 0, 0);
        feed4(32'h41424344); idle();
        expect_out("R5 unit0 hit", 1, 5);

        // R6: same fold address, different tag
        feed4(32'hC1424344); idle();
        expect_out("R6 tag mismatch", 0, 0);

        // R2: gaps between characters
        drive_char(8'h11); idle(); idle(); drive_char(8'h22); idle();
        drive_char(8'h33); drive_char(8'h44); idle();
        expect_out("R2 gapped stream unit1", 1, 100);
        expect_out("R2 no repeat while held", 0, 0);

        // R7: exact latency
        feed4(32'hDEADBEEF);
        expect_out("R7 not before edge n+1", 0, 0);
        expect_out("R7 unit2 hit", 1, 1023);

        // continuous stream through two stored keys
        feed4(32'h30313233); feed4(32'h41424344); idle(); idle();

        // R1: reset in mid-stream
        drive_char(8'h41); drive_char(8'h42); drive_char(8'h43);
        @(negedge clk); rst_n = 0; char_vld = 0;
        @(negedge clk);
        expect_out("R1 mid-stream reset", 0, 0);
        rst_n = 1;
        drive_char(8'h44); idle();
        expect_out("R4 after reset", 0, 0);
        feed4(32'h41424344); idle();
        expect_out("R9 tables kept through reset", 1, 5);

        // R9: rewrite an index, then alias an address above the unit width
        cfg_write(1, 1'b0, int'(fold(32'h11223344, 9)), 25'd200);
        feed4(32'h11223344); idle();
        expect_out("R9 rewritten index", 1, 200);
        cfg_write(3, 1'b0, 10'h081, 25'd77);
        feed4(32'h00000001); idle();
        expect_out("R9 upper address bits ignored", 1, 77);

        repeat (3) idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule